// File: doc/BRIEF.md
# Multicycle Hardwired Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. The datapath has one shared ALU and one shared memory. Each instruction takes several clock cycles. In every cycle the sequencer drives the datapath select, write-enable and ALU-mode lines, and it decides the next step from the current step, the 6-bit opcode held in the instruction register and the ALU overflow flag.

Every instruction begins with the same two steps. The fetch step reads the instruction and advances the PC by four. The decode step reads the operands and precomputes the branch target. After decode the sequencer dispatches into one of five completion paths: register-register ALU, load, store, branch-if-equal or jump. There are two trap steps:
- An opcode outside the supported set leads to the first trap step.
- An overflow raised during the register-register execute step leads to the second trap step.

Both trap steps use the ALU to compute PC minus 4 into the exception-PC register, load the PC with the fixed handler address and write a one-bit cause code. Outputs are a pure function of the current step (Moore style). The datapath, the ALU function decoder and the memory sit outside the block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the block presents the fetch step.
- R2: Fetch step outputs:
  - `mem_rd_o`, `ir_wr_o` and `pc_wr_o` are 1.
  - `alu_b_sel_o`=01 (constant 4), `alu_op_o`=00 (add), `pc_src_o`=00 (ALU result), `alu_a_sel_o`=0 (PC), `addr_from_alu_o`=0.
  - All other outputs are 0.
  - The next step is always decode.
- R3: Decode step outputs:
  - `alu_a_sel_o`=0, `alu_b_sel_o`=11 (immediate shifted by 2), `alu_op_o`=00.
  - All enables are 0.
  - Dispatch on opcode: 0x00 goes to register execute, 0x23 and 0x2B go to address calculation, 0x04 goes to branch, 0x02 goes to jump.
- R4: Load (0x23) path:
  - Address step: `alu_a_sel_o`=1, `alu_b_sel_o`=10, `alu_op_o`=00.
  - Memory read step: `mem_rd_o`=1, `addr_from_alu_o`=1.
  - Write-back step: `reg_wr_o`=1, `wb_from_mem_o`=1, `reg_dst_o`=0.
  - The block then returns to fetch.
- R5: Store (0x2B) path:
  - The same address step as R4.
  - One memory write step: `mem_wr_o`=1, `addr_from_alu_o`=1.
  - The block then returns to fetch.
- R6: Register-register path (opcode 0x00, with `ovf_i` low during execute):
  - Execute step: `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_op_o`=10.
  - Write-back step: `reg_wr_o`=1, `reg_dst_o`=1, `wb_from_mem_o`=0.
  - The block then returns to fetch.
- R7: If `ovf_i` is high during the register-register execute step:
  - The next step is the overflow trap, with `cause_val_o`=1.
  - The write-back step is skipped, so `reg_wr_o` stays 0.
- R8: Any opcode other than 0x00, 0x23, 0x2B, 0x04 and 0x02 goes from decode to the undefined-instruction trap, with `cause_val_o`=0.
- R9: Branch (0x04) step:
  - `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_op_o`=01 (subtract), `pc_wr_cond_o`=1, `pc_src_o`=01.
  - The block then returns to fetch.
- R10: Jump (0x02) step:
  - `pc_wr_o`=1, `pc_src_o`=10 (jump target).
  - The block then returns to fetch.
- R11: Both trap steps drive:
  - `epc_wr_o`=1, `cause_wr_o`=1, `pc_wr_o`=1, `pc_src_o`=11 (handler address 0x8000_0080).
  - `alu_a_sel_o`=0, `alu_b_sel_o`=01, `alu_op_o`=01, so that the ALU computes PC−4.
  - The block then returns to fetch.
- R12: `ovf_i` has no effect in any step other than register-register execute.
- R13: `mem_rd_o` and `mem_wr_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| ovf_i | input | 1 | ALU overflow flag |
| reg_dst_o | output | 1 | Write register from rd (1) or rt (0) |
| reg_wr_o | output | 1 | Register file write enable |
| alu_a_sel_o | output | 1 | ALU operand A: register A (1) or PC (0) |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| wb_from_mem_o | output | 1 | Write-back data from memory data register (1) or ALU output register (0) |
| addr_from_alu_o | output | 1 | Memory address from ALU output register (1) or PC (0) |
| ir_wr_o | output | 1 | Instruction register write |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when the ALU zero flag is set |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 function field |
| alu_b_sel_o | output | 2 | 00 B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| pc_src_o | output | 2 | 00 ALU result, 01 ALU output register, 10 jump target, 11 handler address |
| epc_wr_o | output | 1 | Exception-PC register write |
| cause_wr_o | output | 1 | Cause register write |
| cause_val_o | output | 1 | Cause code: 0 undefined instruction, 1 overflow |

## Verification
Two functions can fall in the same cycle:
- The register-register execute step.
- The overflow trap decision.

During execute, the overflow flag alone chooses between write-back and the trap. The bench sweeps all 64 opcodes twice: once with `ovf_i` held low and once with it held high for the whole instruction. In every step, the full control vector is compared against a step model built from the requirements. This shows that overflow diverts only the register-register path, skipping its register write and setting cause 1, and that it leaves load, store, branch, jump and the undefined-opcode trap unchanged.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH      = 4'd0,
        ST_DECODE     = 4'd1,
        ST_MEMADDR    = 4'd2,
        ST_LOADRD     = 4'd3,
        ST_LOADWB     = 4'd4,
        ST_STORE      = 4'd5,
        ST_REXEC      = 4'd6,
        ST_RWB        = 4'd7,
        ST_BRANCH     = 4'd8,
        ST_JUMP       = 4'd9,
        ST_TRAP_UNDEF = 4'd10,
        ST_TRAP_OVF   = 4'd11
    } state_e;

    localparam logic [1:0] ALU_ADD   = 2'b00;
    localparam logic [1:0] ALU_SUB   = 2'b01;
    localparam logic [1:0] ALU_FUNCT = 2'b10;

    localparam logic [1:0] BSEL_REG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM  = 2'b10;
    localparam logic [1:0] BSEL_IMM4 = 2'b11;

    localparam logic [1:0] PCS_ALU   = 2'b00;
    localparam logic [1:0] PCS_OUT   = 2'b01;
    localparam logic [1:0] PCS_JMP   = 2'b10;
    localparam logic [1:0] PCS_TRAP  = 2'b11;

    typedef struct packed {
        logic       reg_dst;
        logic       reg_wr;
        logic       alu_a_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       wb_from_mem;
        logic       addr_from_alu;
        logic       ir_wr;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] alu_op;
        logic [1:0] alu_b_sel;
        logic [1:0] pc_src;
        logic       epc_wr;
        logic       cause_wr;
        logic       cause_val;
    } ctrl_t;

    typedef struct packed {
        state_e state;
    } fsm_t;

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
#(
    parameter int              OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_RRR = 6'h00,
    parameter logic [OPC_W-1:0] OPC_LD  = 6'h23,
    parameter logic [OPC_W-1:0] OPC_ST  = 6'h2B,
    parameter logic [OPC_W-1:0] OPC_BEQ = 6'h04,
    parameter logic [OPC_W-1:0] OPC_JMP = 6'h02
) (
    input  state_e           state_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             ovf_i,
    output state_e           state_o
);

    // Dispatch from decode; anything unlisted is an undefined instruction.
    state_e dispatch;
    always_comb begin
        if (opcode_i == OPC_RRR)                            dispatch = ST_REXEC;
        else if (opcode_i == OPC_LD || opcode_i == OPC_ST)  dispatch = ST_MEMADDR;
        else if (opcode_i == OPC_BEQ)                       dispatch = ST_BRANCH;
        else if (opcode_i == OPC_JMP)                       dispatch = ST_JUMP;
        else                                                dispatch = ST_TRAP_UNDEF;
    end

    always_comb begin
        state_o = ST_FETCH;
        case (state_i)
            ST_FETCH:   state_o = ST_DECODE;
            ST_DECODE:  state_o = dispatch;
            ST_MEMADDR: state_o = (opcode_i == OPC_LD) ? ST_LOADRD : ST_STORE;
            ST_LOADRD:  state_o = ST_LOADWB;
            // Overflow is only meaningful in the execute step of the ALU path.
            ST_REXEC:   state_o = ovf_i ? ST_TRAP_OVF : ST_RWB;
            default:    state_o = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_e state_i,
    output ctrl_t  ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        case (state_i)
            ST_FETCH: begin
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.ir_wr     = 1'b1;
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.alu_b_sel = BSEL_FOUR;
                ctrl_o.alu_op    = ALU_ADD;
                ctrl_o.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl_o.alu_b_sel = BSEL_IMM4;
                ctrl_o.alu_op    = ALU_ADD;
            end
            ST_MEMADDR: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = BSEL_IMM;
                ctrl_o.alu_op    = ALU_ADD;
            end
            ST_LOADRD: begin
                ctrl_o.mem_rd        = 1'b1;
                ctrl_o.addr_from_alu = 1'b1;
            end
            ST_LOADWB: begin
                ctrl_o.reg_wr      = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
            end
            ST_STORE: begin
                ctrl_o.mem_wr        = 1'b1;
                ctrl_o.addr_from_alu = 1'b1;
            end
            ST_REXEC: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = BSEL_REG;
                ctrl_o.alu_op    = ALU_FUNCT;
            end
            ST_RWB: begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.reg_dst = 1'b1;
            end
            ST_BRANCH: begin
                ctrl_o.alu_a_sel  = 1'b1;
                ctrl_o.alu_b_sel  = BSEL_REG;
                ctrl_o.alu_op     = ALU_SUB;
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.pc_src     = PCS_OUT;
            end
            ST_JUMP: begin
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.pc_src = PCS_JMP;
            end
            ST_TRAP_UNDEF, ST_TRAP_OVF: begin
                // ALU backs the PC up by four for the exception-PC register.
                ctrl_o.alu_a_sel = 1'b0;
                ctrl_o.alu_b_sel = BSEL_FOUR;
                ctrl_o.alu_op    = ALU_SUB;
                ctrl_o.epc_wr    = 1'b1;
                ctrl_o.cause_wr  = 1'b1;
                ctrl_o.cause_val = (state_i == ST_TRAP_OVF);
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.pc_src    = PCS_TRAP;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int               OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_RRR = 6'h00,
    parameter logic [OPC_W-1:0] OPC_LD  = 6'h23,
    parameter logic [OPC_W-1:0] OPC_ST  = 6'h2B,
    parameter logic [OPC_W-1:0] OPC_BEQ = 6'h04,
    parameter logic [OPC_W-1:0] OPC_JMP = 6'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             ovf_i,
    output logic             reg_dst_o,
    output logic             reg_wr_o,
    output logic             alu_a_sel_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             wb_from_mem_o,
    output logic             addr_from_alu_o,
    output logic             ir_wr_o,
    output logic             pc_wr_o,
    output logic             pc_wr_cond_o,
    output logic [1:0]       alu_op_o,
    output logic [1:0]       alu_b_sel_o,
    output logic [1:0]       pc_src_o,
    output logic             epc_wr_o,
    output logic             cause_wr_o,
    output logic             cause_val_o
);

    fsm_t   fsm_d, fsm_q;
    state_e state_nxt;
    ctrl_t  ctrl;

    mcc_next_state #(
        .OPC_W  (OPC_W),
        .OPC_RRR(OPC_RRR),
        .OPC_LD (OPC_LD),
        .OPC_ST (OPC_ST),
        .OPC_BEQ(OPC_BEQ),
        .OPC_JMP(OPC_JMP)
    ) u_next (
        .state_i (fsm_q.state),
        .opcode_i(opcode_i),
        .ovf_i   (ovf_i),
        .state_o (state_nxt)
    );

    mcc_ctrl_decode u_dec (
        .state_i(fsm_q.state),
        .ctrl_o (ctrl)
    );

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.state = state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q.state <= ST_FETCH;
        else        fsm_q       <= fsm_d;
    end

    assign reg_dst_o       = ctrl.reg_dst;
    assign reg_wr_o        = ctrl.reg_wr;
    assign alu_a_sel_o     = ctrl.alu_a_sel;
    assign mem_rd_o        = ctrl.mem_rd;
    assign mem_wr_o        = ctrl.mem_wr;
    assign wb_from_mem_o   = ctrl.wb_from_mem;
    assign addr_from_alu_o = ctrl.addr_from_alu;
    assign ir_wr_o         = ctrl.ir_wr;
    assign pc_wr_o         = ctrl.pc_wr;
    assign pc_wr_cond_o    = ctrl.pc_wr_cond;
    assign alu_op_o        = ctrl.alu_op;
    assign alu_b_sel_o     = ctrl.alu_b_sel;
    assign pc_src_o        = ctrl.pc_src;
    assign epc_wr_o        = ctrl.epc_wr;
    assign cause_wr_o      = ctrl.cause_wr;
    assign cause_val_o     = ctrl.cause_val;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
    parameter int OPC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] opcode_i,
    input logic             ovf_i,
    input logic             reg_dst_o,
    input logic             reg_wr_o,
    input logic             alu_a_sel_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             wb_from_mem_o,
    input logic             addr_from_alu_o,
    input logic             ir_wr_o,
    input logic             pc_wr_o,
    input logic             pc_wr_cond_o,
    input logic [1:0]       alu_op_o,
    input logic [1:0]       alu_b_sel_o,
    input logic [1:0]       pc_src_o,
    input logic             epc_wr_o,
    input logic             cause_wr_o,
    input logic             cause_val_o
);

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ir_wr_o && mem_rd_o && pc_wr_o));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr_o |=> (alu_b_sel_o == 2'b11 && !pc_wr_o && !mem_rd_o));

    assert_load_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && addr_from_alu_o) |=> (reg_wr_o && wb_from_mem_o && !reg_dst_o));

    assert_alu_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op_o == 2'b10 && !ovf_i) |=> (reg_wr_o && reg_dst_o));

    assert_ovf_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op_o == 2'b10 && ovf_i) |=> (!reg_wr_o && epc_wr_o && cause_val_o));

    assert_trap_returns_R11: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr_o |=> ir_wr_o);

    assert_mem_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.OPC_W(OPC_W)) u_chk (.*);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       ovf;
    logic       reg_dst, reg_wr, alu_a_sel, mem_rd, mem_wr, wb_mem, addr_alu;
    logic       ir_wr, pc_wr, pc_wr_cond, epc_wr, cause_wr, cause_val;
    logic [1:0] alu_op, alu_b_sel, pc_src;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .ovf_i(ovf),
        .reg_dst_o(reg_dst), .reg_wr_o(reg_wr), .alu_a_sel_o(alu_a_sel),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .wb_from_mem_o(wb_mem),
        .addr_from_alu_o(addr_alu), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr),
        .pc_wr_cond_o(pc_wr_cond), .alu_op_o(alu_op), .alu_b_sel_o(alu_b_sel),
        .pc_src_o(pc_src), .epc_wr_o(epc_wr), .cause_wr_o(cause_wr),
        .cause_val_o(cause_val)
    );

    logic [18:0] act;
    assign act = {reg_dst, reg_wr, alu_a_sel, mem_rd, mem_wr, wb_mem, addr_alu,
                  ir_wr, pc_wr, pc_wr_cond, alu_op, alu_b_sel, pc_src,
                  epc_wr, cause_wr, cause_val};

    // Step numbering of the model: 0 fetch, 1 decode, 2 address, 3 load read,
    // 4 load write-back, 5 store, 6 ALU execute, 7 ALU write-back, 8 branch,
    // 9 jump, 10 undefined trap, 11 overflow trap.
    function automatic int model_next(int s, logic [5:0] op, logic ov);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'h00) return 6;
                if (op == 6'h23 || op == 6'h2B) return 2;
                if (op == 6'h04) return 8;
                if (op == 6'h02) return 9;
                return 10;
            end
            2: return (op == 6'h23) ? 3 : 5;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [18:0] expv(int s);
        logic rd = 0, rw = 0, as = 0, mr = 0, mw = 0, mtr = 0, iod = 0, irw = 0;
        logic pw = 0, pwc = 0, ew = 0, cw = 0, cv = 0;
        logic [1:0] op = 2'b00, bs = 2'b00, ps = 2'b00;
        case (s)
            0:  begin mr = 1; irw = 1; pw = 1; bs = 2'b01; end
            1:  begin bs = 2'b11; end
            2:  begin as = 1; bs = 2'b10; end
            3:  begin mr = 1; iod = 1; end
            4:  begin rw = 1; mtr = 1; end
            5:  begin mw = 1; iod = 1; end
            6:  begin as = 1; op = 2'b10; end
            7:  begin rw = 1; rd = 1; end
            8:  begin as = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10, 11: begin
                bs = 2'b01; op = 2'b01; ew = 1; cw = 1; pw = 1; ps = 2'b11;
                cv = (s == 11);
            end
            default: ;
        endcase
        return {rd, rw, as, mr, mw, mtr, iod, irw, pw, pwc, op, bs, ps, ew, cw, cv};
    endfunction

    function automatic string tag_of(int s, logic ov);
        if (ov && s != 6 && s < 10) return "R12";
        case (s)
            0: return "R2";  1: return "R3";  2, 3, 4: return "R4";
            5: return "R5";  6, 7: return "R6"; 8: return "R9";
            9: return "R10"; 10: return "R8"; default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [18:0] got, logic [18:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, want);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n  = 1'b0;
        opcode = 6'h00;
        ovf    = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", act, expv(0));  // reset holds fetch
        for (int ov = 0; ov < 2; ov++) begin
            for (int op = 0; op < 64; op++) begin
                int ms;
                int steps;
                opcode = op[5:0];
                ovf    = ov[0];
                rst_n  = 1'b1;
                ms     = 0;
                steps  = 0;
                do begin
                    check(tag_of(ms, ov[0]), act, expv(ms));
                    check("R13", {18'd0, mem_rd & mem_wr}, 19'd0);
                    if (ms >= 10)
                        check("R11", {17'd0, epc_wr & cause_wr & pc_wr, pc_src == 2'b11},
                              {17'd0, 2'b11});
                    if (ms == 4 || ms == 7)
                        check("R6", {18'd0, ov[0] & (ms == 7) & reg_wr}, 19'd0);
                    ms = model_next(ms, opcode, ovf);
                    steps++;
                    @(negedge clk);
                end while (ms != 0 && steps < 8);
            end
        end
        // Reset reasserted mid-instruction: the block presents fetch again.
        opcode = 6'h23;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", act, expv(0));
        finish_run();
    end

endmodule